// File: doc/BRIEF.md
# Reed-Solomon Sector Parity Engine

This block computes Reed-Solomon check symbols for a 512-byte flash sector while the bytes stream past it, one byte per clock. Arithmetic is over GF(2^10) with field polynomial x^10 + x^3 + 1. The generator polynomial has six roots, alpha^0 to alpha^5, so six 10-bit check symbols come out. They are packed into eight bytes. Each incoming byte is bit-inverted and zero-extended to a 10-bit symbol before it enters the division circuit. As a result, an erased page of all 0xFF bytes yields a parity image of all 0xFF.

In write use, the host clears the engine and selects generate mode with streaming enabled. It then pushes the sector and reads the inverted parity bank, which is what gets stored. In read use, the host clears the engine with streaming enabled but generate mode off. It pushes the 512 data bytes followed by the 8 stored parity bytes. The engine unpacks the stored parity, divides it through and latches a fast error flag from the remainder. The host then reads the remainder, which is bit-reversed per byte, from the normal bank and corrects the data in software.

Top module: `rs_sector_ecc`

## Requirements
- R1: After reset the control register (address 0) reads 0x0000 and the status register (address 1) reads 0x0000. The normal bank (addresses 8..15) reads 0x00 in every byte, and the inverted bank (addresses 16..23) reads 0xFF in every byte.
- R2: In generate mode (control bit 6 = 1, bit 5 = 1), the first 512 accepted bytes are processed as follows. Byte i becomes the symbol s_i = {2'b00, ~byte}. The engine forms the remainder R(x) = S(x)*x^6 mod g(x), where g(x) = (x+1)(x+a)...(x+a^5) over GF(2^10) with polynomial 0x409. The packed 64-bit image P places the coefficient of x^k at bits [(5-k)*10+9 : (5-k)*10], with bits 63..60 equal to 0. Inverted-bank byte k reads ~P[8k+7:8k].
- R3: For an all-0xFF sector, all eight inverted-bank bytes read 0xFF, including the four unused top bits of byte 7.
- R4: Normal-bank byte k reads P[8k+7:8k] with its bit order reversed (bit 0 swapped with bit 7, and so on).
- R5: In read mode (bit 6 = 0, bit 5 = 1), the engine takes 512 data bytes and then the 8 stored inverted-bank bytes. It unpacks the stored bytes into six symbols and divides them through. Within 8 cycles of the last byte, status bit 0 (check done) is 1. If the stored parity matches the data, status bit 7 is 0 and the normal bank reads all zero.
- R6: In read mode, if any data byte or parity byte disagrees with the stored code, status bit 7 (error) is 1 and the normal bank is non-zero.
- R7: While control bit 5 is 0, strobed bytes are ignored and the banks keep their value. Re-enabling without the clear bit resumes the computation where it stopped.
- R8: Bytes strobed after the codeword is complete are ignored: after 512 bytes in generate mode, and after 520 bytes in read mode.
- R9: Writing control bit 7 zeroes the remainder, the byte count and the status register in one cycle. Bit 7 is not stored and reads back as 0, while bits 6 and 5 read back as written.
- R10: Writes to bank addresses have no effect on any bank byte.
- R11: If a byte is strobed in the same cycle as a control write with bit 7 set, the clear wins and that byte is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | AW (5) | Register address |
| reg_wdata | input | DW (16) | Register write data |
| reg_rdata | output | DW (16) | Register read data, combinational from reg_addr |
| in_valid | input | 1 | Data byte strobe |
| in_byte | input | 8 | Data byte |

## Verification
A control write that carries the clear bit can land in the same cycle as a valid data byte. When it does, the engine must drop that byte rather than start the new codeword with it. The bench first enables streaming, then issues a clear write and a strobe of byte 0x00 on the same clock, and then streams a full sector. The collision is judged by comparing the resulting parity with a model of the following 512 bytes only. If the colliding byte had been accepted, its nonzero inverted symbol would shift the whole remainder.

// File: rtl/rsecc_pkg.sv
`timescale 1ns/1ps
package rsecc_pkg;
   // register map; bank bases must be aligned to a power of two >= ECC byte count
   localparam int CTL_ADDR  = 0;
   localparam int STAT_ADDR = 1;
   localparam int NRM_BASE  = 8;
   localparam int INV_BASE  = 16;

   // control register bit positions
   localparam int CTL_CLR_BIT = 7;
   localparam int CTL_GEN_BIT = 6;
   localparam int CTL_EN_BIT  = 5;

   // status register bit positions
   localparam int STAT_ERR_BIT  = 7;
   localparam int STAT_DONE_BIT = 0;

   function automatic logic [7:0] flip_byte(input logic [7:0] b);
      logic [7:0] r;
      for (int i = 0; i < 8; i++) r[i] = b[7-i];
      return r;
   endfunction
endpackage

// File: rtl/rsecc_lfsr.sv
`timescale 1ns/1ps
module rsecc_lfsr #(
   parameter int          SYM_W = 10,
   parameter int          NPAR  = 6,
   parameter logic [31:0] POLY  = 32'h409,
   parameter int          FCR   = 0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr,
   input  logic                    step,
   input  logic [SYM_W-1:0]        sym,
   output logic [NPAR*SYM_W-1:0]   rem
);
   localparam int NW = NPAR*SYM_W;
   localparam int GW = (NPAR+1)*SYM_W;

   typedef logic [SYM_W-1:0] sym_t;

   function automatic sym_t gf_mul(input sym_t a, input sym_t b);
      sym_t acc;
      sym_t x;
      acc = '0;
      x   = a;
      for (int i = 0; i < SYM_W; i++) begin
         if (b[i]) acc ^= x;
         x = x[SYM_W-1] ? ((x << 1) ^ POLY[SYM_W-1:0]) : (x << 1);
      end
      return acc;
   endfunction

   function automatic logic [GW-1:0] gen_poly();
      logic [GW-1:0] g;
      sym_t root;
      g = '0;
      g[SYM_W-1:0] = sym_t'(1);
      root = sym_t'(1);
      for (int j = 0; j < FCR; j++) root = gf_mul(root, sym_t'(2));
      for (int i = 0; i < NPAR; i++) begin
         for (int k = NPAR; k > 0; k--)
            g[k*SYM_W +: SYM_W] = g[(k-1)*SYM_W +: SYM_W] ^ gf_mul(g[k*SYM_W +: SYM_W], root);
         g[0 +: SYM_W] = gf_mul(g[0 +: SYM_W], root);
         root = gf_mul(root, sym_t'(2));
      end
      return g;
   endfunction

   localparam logic [GW-1:0] GEN = gen_poly();

   if (POLY[SYM_W] != 1'b1) begin : g_bad_poly
      $error("field polynomial degree does not match symbol width");
   end
   if (NPAR < 2) begin : g_bad_npar
      $error("at least two check symbols are required");
   end

   logic [NW-1:0] rq;
   logic [NW-1:0] nxt;
   sym_t          fb;

   assign fb = sym ^ rq[NW-1 -: SYM_W];

   for (genvar k = 0; k < NPAR; k++) begin : g_stage
      if (k == 0) begin : g_lo
         assign nxt[0 +: SYM_W] = gf_mul(GEN[0 +: SYM_W], fb);
      end else begin : g_hi
         assign nxt[k*SYM_W +: SYM_W] = rq[(k-1)*SYM_W +: SYM_W] ^ gf_mul(GEN[k*SYM_W +: SYM_W], fb);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rq <= '0;
      else if (clr)   rq <= '0;
      else if (step)  rq <= nxt;
   end

   assign rem = rq;

   assert_clear_zeroes_R9: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (rem == '0));

   assert_idle_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !step) |=> $stable(rem));
endmodule

// File: rtl/rsecc_seq.sv
`timescale 1ns/1ps
module rsecc_seq #(
   parameter int SYM_W      = 10,
   parameter int NPAR       = 6,
   parameter int DATA_BYTES = 512,
   parameter int ECC_BYTES  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             gen_mode,
   input  logic             feed_en,
   input  logic             in_valid,
   input  logic [7:0]       in_byte,
   input  logic             rem_zero,
   output logic             step,
   output logic [SYM_W-1:0] sym,
   output logic             chk_done,
   output logic             chk_err
);
   localparam int TOTAL = DATA_BYTES + ECC_BYTES;
   localparam int CW    = $clog2(TOTAL + 1);
   localparam int LW    = $clog2(NPAR + 1);
   localparam int CB    = ECC_BYTES * 8;

   if (SYM_W <= 8) begin : g_bad_sym
      $error("symbol width must exceed the byte width");
   end
   if (CB < NPAR*SYM_W) begin : g_bad_pack
      $error("parity bytes cannot hold the check symbols");
   end

   logic [CW-1:0] cnt;
   logic [LW-1:0] left;
   logic [CB-1:0] coll;
   logic          pend;
   logic          accept, is_data, data_step, coll_shift, feeding, last_byte;

   assign is_data    = (cnt < CW'(DATA_BYTES));
   assign accept     = in_valid && feed_en && !clr && (cnt < CW'(TOTAL)) && !(gen_mode && !is_data);
   assign data_step  = accept && is_data;
   assign coll_shift = accept && !is_data;
   assign last_byte  = coll_shift && (cnt == CW'(TOTAL - 1));
   assign feeding    = (left != '0);

   assign step = data_step || feeding;
   assign sym  = feeding ? ~coll[SYM_W-1:0] : {{(SYM_W-8){1'b0}}, ~in_byte};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         left     <= '0;
         coll     <= '0;
         pend     <= 1'b0;
         chk_done <= 1'b0;
         chk_err  <= 1'b0;
      end else if (clr) begin
         cnt      <= '0;
         left     <= '0;
         coll     <= '0;
         pend     <= 1'b0;
         chk_done <= 1'b0;
         chk_err  <= 1'b0;
      end else begin
         if (accept) cnt <= cnt + 1'b1;
         if (coll_shift) coll <= {in_byte, coll[CB-1:8]};
         else if (feeding) coll <= coll >> SYM_W;
         if (last_byte) left <= LW'(NPAR);
         else if (feeding) left <= left - 1'b1;
         pend <= feeding && (left == LW'(1));
         if (pend) begin
            chk_done <= 1'b1;
            chk_err  <= !rem_zero;
         end
      end
   end

   assert_count_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(TOTAL));

   assert_feed_after_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
      feeding |-> (cnt == CW'(TOTAL)));

   assert_clear_drops_byte_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && in_valid) |=> (cnt == '0));

   assert_disabled_no_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!feed_en && !clr) |=> $stable(cnt));
endmodule

// File: rtl/rsecc_regs.sv
`timescale 1ns/1ps
module rsecc_regs
   import rsecc_pkg::*;
#(
   parameter int SYM_W     = 10,
   parameter int NPAR      = 6,
   parameter int ECC_BYTES = 8,
   parameter int AW        = 5,
   parameter int DW        = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [AW-1:0]         addr,
   input  logic [DW-1:0]         wdata,
   input  logic [NPAR*SYM_W-1:0] rem,
   input  logic                  chk_done,
   input  logic                  chk_err,
   output logic [DW-1:0]         rdata,
   output logic                  clr,
   output logic                  gen_mode,
   output logic                  feed_en
);
   localparam int CB = ECC_BYTES * 8;
   localparam int IW = (ECC_BYTES > 1) ? $clog2(ECC_BYTES) : 1;

   if (DW < 8) begin : g_bad_dw
      $error("register width must hold one byte");
   end
   if (ECC_BYTES > INV_BASE - NRM_BASE) begin : g_bad_map
      $error("parity banks overlap in the register map");
   end
   if ((1 << AW) < INV_BASE + ECC_BYTES) begin : g_bad_aw
      $error("address width too small for the register map");
   end

   logic          ctl_hit;
   logic [CB-1:0] plain;
   logic [AW-1:0] off_n, off_i;
   logic          in_nrm, in_inv;
   logic          unused_wbits;

   assign ctl_hit  = wr_en && (addr == AW'(CTL_ADDR));
   assign clr      = ctl_hit && wdata[CTL_CLR_BIT];
   assign unused_wbits = ^{wdata[DW-1:8], wdata[4:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gen_mode <= 1'b0;
         feed_en  <= 1'b0;
      end else if (ctl_hit) begin
         gen_mode <= wdata[CTL_GEN_BIT];
         feed_en  <= wdata[CTL_EN_BIT];
      end
   end

   // highest-order coefficient lands in the lowest bits
   for (genvar m = 0; m < NPAR; m++) begin : g_pack
      assign plain[m*SYM_W +: SYM_W] = rem[(NPAR-1-m)*SYM_W +: SYM_W];
   end
   if (CB > NPAR*SYM_W) begin : g_pad
      assign plain[CB-1:NPAR*SYM_W] = '0;
   end

   assign off_n  = addr - AW'(NRM_BASE);
   assign off_i  = addr - AW'(INV_BASE);
   assign in_nrm = (addr >= AW'(NRM_BASE)) && (addr < AW'(NRM_BASE + ECC_BYTES));
   assign in_inv = (addr >= AW'(INV_BASE)) && (addr < AW'(INV_BASE + ECC_BYTES));

   always_comb begin
      rdata = '0;
      if (addr == AW'(CTL_ADDR)) begin
         rdata[CTL_GEN_BIT] = gen_mode;
         rdata[CTL_EN_BIT]  = feed_en;
      end else if (addr == AW'(STAT_ADDR)) begin
         rdata[STAT_ERR_BIT]  = chk_err;
         rdata[STAT_DONE_BIT] = chk_done;
      end else if (in_nrm) begin
         rdata[7:0] = flip_byte(plain[off_n[IW-1:0]*8 +: 8]);
      end else if (in_inv) begin
         rdata[7:0] = ~plain[off_i[IW-1:0]*8 +: 8];
      end
   end

   assert_clear_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!chk_done && !chk_err));

   assert_ctl_follows_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_hit |=> (feed_en == $past(wdata[CTL_EN_BIT])));
endmodule

// File: rtl/rs_sector_ecc.sv
`timescale 1ns/1ps
module rs_sector_ecc #(
   parameter int          SYM_W      = 10,
   parameter int          NPAR       = 6,
   parameter logic [31:0] POLY       = 32'h409,
   parameter int          FCR        = 0,
   parameter int          DATA_BYTES = 512,
   parameter int          AW         = 5,
   parameter int          DW         = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_wr_en,
   input  logic [AW-1:0] reg_addr,
   input  logic [DW-1:0] reg_wdata,
   output logic [DW-1:0] reg_rdata,
   input  logic          in_valid,
   input  logic [7:0]    in_byte
);
   localparam int ECC_BYTES = (NPAR*SYM_W + 7) / 8;

   logic                  clr, gen_mode, feed_en, step, chk_done, chk_err;
   logic [SYM_W-1:0]      sym;
   logic [NPAR*SYM_W-1:0] rem;

   rsecc_regs #(.SYM_W(SYM_W), .NPAR(NPAR), .ECC_BYTES(ECC_BYTES), .AW(AW), .DW(DW)) regs_i (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr), .wdata(reg_wdata),
      .rem(rem), .chk_done(chk_done), .chk_err(chk_err), .rdata(reg_rdata),
      .clr(clr), .gen_mode(gen_mode), .feed_en(feed_en));

   rsecc_seq #(.SYM_W(SYM_W), .NPAR(NPAR), .DATA_BYTES(DATA_BYTES), .ECC_BYTES(ECC_BYTES)) seq_i (
      .clk(clk), .rst_n(rst_n), .clr(clr), .gen_mode(gen_mode), .feed_en(feed_en),
      .in_valid(in_valid), .in_byte(in_byte), .rem_zero(rem == '0),
      .step(step), .sym(sym), .chk_done(chk_done), .chk_err(chk_err));

   rsecc_lfsr #(.SYM_W(SYM_W), .NPAR(NPAR), .POLY(POLY), .FCR(FCR)) lfsr_i (
      .clk(clk), .rst_n(rst_n), .clr(clr), .step(step), .sym(sym), .rem(rem));
endmodule

// File: tb/rs_sector_ecc_tb.sv
`timescale 1ns/1ps
module rs_sector_ecc_tb_top;
   localparam int CTL = 0, STAT = 1, NRM = 8, INV = 16;
   // {kind[20:19], seed[18:11], flip_index[10:1] (3FF = none), expect_error[0]}
   localparam logic [20:0] VEC [6] = '{
      {2'd0, 8'h00, 10'h3FF, 1'b0},
      {2'd1, 8'h00, 10'h3FF, 1'b0},
      {2'd2, 8'h5A, 10'd100, 1'b1},
      {2'd3, 8'h3C, 10'h3FF, 1'b0},
      {2'd3, 8'h91, 10'd515, 1'b1},
      {2'd0, 8'h00, 10'd0,   1'b1}
   };

   logic        clk = 0, rst_n = 0, reg_wr_en = 0, in_valid = 0;
   logic [4:0]  reg_addr = 0;
   logic [15:0] reg_wdata = 0, reg_rdata;
   logic [7:0]  in_byte = 0;
   int          errors = 0, checks = 0;
   bit          done_flag = 0;
   logic [9:0]  gpoly [7];
   logic [7:0]  dbuf [520];
   logic [63:0] mpack;

   always #2.5 clk = ~clk;

   rs_sector_ecc dut_i (.clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_valid(in_valid), .in_byte(in_byte));

   function automatic logic [9:0] gmul(input logic [9:0] a, input logic [9:0] b);
      logic [9:0] acc = 0, x = a;
      for (int i = 0; i < 10; i++) begin
         if (b[i]) acc ^= x;
         x = x[9] ? ((x << 1) ^ 10'h009) : (x << 1);
      end
      return acc;
   endfunction

   function automatic logic [7:0] rev8(input logic [7:0] b);
      logic [7:0] r;
      for (int i = 0; i < 8; i++) r[i] = b[7-i];
      return r;
   endfunction

   function automatic logic [7:0] pat(input int kind, input logic [7:0] seed, input int i);
      int t;
      case (kind)
         0: return 8'hFF;
         1: return 8'h00;
         2: return 8'(i) ^ seed;
         default: begin t = i*37 + int'(seed)*11 + (i >> 3); return 8'(t); end
      endcase
   endfunction

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [15:0] d);
      @(negedge clk); reg_wr_en = 1; reg_addr = 5'(a); reg_wdata = d;
      @(negedge clk); reg_wr_en = 0;
   endtask

   task automatic rd(input int a, output logic [15:0] v);
      @(negedge clk); reg_addr = 5'(a); #1; v = reg_rdata;
   endtask

   task automatic stream(input int s, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); in_valid = 1; in_byte = dbuf[s+i];
      end
      @(negedge clk); in_valid = 0;
   endtask

   task automatic stream_const(input logic [7:0] v, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); in_valid = 1; in_byte = v;
      end
      @(negedge clk); in_valid = 0;
   endtask

   task automatic fill(input int kind, input logic [7:0] seed);
      for (int i = 0; i < 512; i++) dbuf[i] = pat(kind, seed, i);
   endtask

   task automatic model_gen();
      logic [9:0] r [6];
      logic [9:0] fb;
      for (int k = 0; k < 6; k++) r[k] = 0;
      for (int i = 0; i < 512; i++) begin
         fb = {2'b00, ~dbuf[i]} ^ r[5];
         for (int k = 5; k > 0; k--) r[k] = r[k-1] ^ gmul(gpoly[k], fb);
         r[0] = gmul(gpoly[0], fb);
      end
      mpack = 0;
      for (int m = 0; m < 6; m++) mpack[m*10 +: 10] = r[5-m];
   endtask

   task automatic check_banks(input string inv_req);
      logic [15:0] v;
      for (int k = 0; k < 8; k++) begin
         rd(INV + k, v); chk(inv_req, v, {8'h00, ~mpack[k*8 +: 8]});
         rd(NRM + k, v); chk("R4", v, {8'h00, rev8(mpack[k*8 +: 8])});
      end
   endtask

   task automatic summary();
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done_flag) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         summary();
      end
   end

   initial begin
      logic [15:0] v;
      logic [9:0]  root;
      logic        nz;
      // generator (x+1)(x+a)...(x+a^5)
      for (int k = 0; k < 7; k++) gpoly[k] = 0;
      gpoly[0] = 1; root = 1;
      for (int i = 0; i < 6; i++) begin
         for (int k = 6; k > 0; k--) gpoly[k] = gpoly[k-1] ^ gmul(gpoly[k], root);
         gpoly[0] = gmul(gpoly[0], root);
         root = gmul(root, 10'd2);
      end

      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      rd(CTL, v);  chk("R1", v, 16'h0000);
      rd(STAT, v); chk("R1", v, 16'h0000);
      for (int k = 0; k < 8; k++) begin
         rd(INV + k, v); chk("R1", v, 16'h00FF);
         rd(NRM + k, v); chk("R1", v, 16'h0000);
      end

      // table walk: generate then verify each sector
      for (int e = 0; e < 6; e++) begin
         int kind; logic [7:0] seed; int flip; logic xerr;
         kind = int'(VEC[e][20:19]); seed = VEC[e][18:11];
         flip = int'(VEC[e][10:1]); xerr = VEC[e][0];
         fill(kind, seed); model_gen();
         wr(CTL, 16'h00E0);
         stream(0, 512);
         check_banks(kind == 0 ? "R3" : "R2");
         if (flip != 10'h3FF && flip < 512) dbuf[flip] ^= 8'h01;
         for (int k = 0; k < 8; k++) dbuf[512+k] = ~mpack[k*8 +: 8];
         if (flip != 10'h3FF && flip >= 512) dbuf[flip] ^= 8'h01;
         wr(CTL, 16'h00A0);
         stream(0, 520);
         stream_const(8'h33, 3);   // R8: beyond the read codeword
         repeat (8) @(negedge clk);
         rd(STAT, v); chk(xerr ? "R6" : "R5", v, {8'h00, xerr, 6'b0, 1'b1});
         nz = 0;
         for (int k = 0; k < 8; k++) begin
            rd(NRM + k, v);
            if (!xerr) chk("R5", v, 16'h0000);
            nz |= (v != 0);
         end
         if (xerr) chk("R6", 16'(nz), 16'h0001);
         // R9: clear resets status, bit 7 not stored
         wr(CTL, 16'h00C0);
         rd(CTL, v);  chk("R9", v, 16'h0040);
         rd(STAT, v); chk("R9", v, 16'h0000);
         rd(INV + 3, v); chk("R9", v, 16'h00FF);
      end

      // R7: freeze mid-sector, junk ignored, resume
      fill(3, 8'h27); model_gen();
      wr(CTL, 16'h00E0);
      stream(0, 200);
      wr(CTL, 16'h0000);
      begin
         logic [15:0] snap [8];
         for (int k = 0; k < 8; k++) rd(INV + k, snap[k]);
         stream_const(8'h5A, 40);
         for (int k = 0; k < 8; k++) begin rd(INV + k, v); chk("R7", v, snap[k]); end
      end
      wr(CTL, 16'h0060);
      stream(200, 312);
      check_banks("R7");

      // R8: extra bytes after 512 in generate mode
      stream_const(8'hC3, 5);
      check_banks("R8");

      // R10: writes to banks ignored
      wr(NRM, 16'h1234);
      wr(INV + 7, 16'hABCD);
      check_banks("R10");

      // R11: clear and a byte strobe in the same cycle
      fill(2, 8'h77); model_gen();
      wr(CTL, 16'h0060);
      @(negedge clk); reg_wr_en = 1; reg_addr = 5'(CTL); reg_wdata = 16'h00E0;
      in_valid = 1; in_byte = 8'h00;
      @(negedge clk); reg_wr_en = 0; in_valid = 0;
      stream(0, 512);
      check_banks("R11");

      done_flag = 1;
      summary();
   end
endmodule